// File: doc/BRIEF.md
# Variable-Rate Bit-Pair Packer

This block sits in a receive path below the coding sublayer. Each clock cycle, an upstream stage delivers zero, one or two freshly recovered line bits on a two-lane data bus, together with a two-bit count saying how many of those lanes hold new bits. The newest bit always travels on the upper lane. The block puts the bits back in arrival order and cuts the stream into fixed-width code groups. Each finished group goes out with a strobe that lasts one cycle.

A later alignment stage can move the group boundary by one bit. It does this by pulsing a slip input, which throws away one incoming bit. Because two bits can arrive together, a group boundary may fall between the two bits of the same cycle. In that case the older bit closes the current group and the newer bit opens the next one.

Top module: `bitpair_packer`

## Requirements
- R1: While `rst_n` is low, `grp_stb` and `grp_data` are 0 and any partly built group is discarded. `rst_n` takes effect asynchronously. Its release is synchronized, so bits offered within the first two rising edges after release may be lost.
- R2: `rx_cnt` = 0 means no new bit is present, and the cycle adds nothing to the group under construction.
- R3: `rx_cnt` = 1 means only `rx_bits[1]` is a new bit. `rx_bits[0]` is ignored in that cycle.
- R4: A value of `rx_cnt` with bit 1 set (2 or 3) means both lanes carry new bits, with `rx_bits[0]` older than `rx_bits[1]`. The value 3 behaves exactly like 2.
- R5: Groups are MSB-first: `grp_data[GRP_W-1]` holds the earliest accepted bit of the group and `grp_data[0]` the latest.
- R6: `grp_stb` is high for exactly one cycle, right after the rising edge that samples the bit completing a group. `grp_data` carries that group in the same cycle.
- R7: When a group completes on `rx_bits[0]` of a two-bit cycle, `rx_bits[1]` of that cycle becomes the first bit of the next group.
- R8: A cycle with `slip` high discards the oldest new bit of that cycle. If the cycle carries no new bit, the next bit to arrive is discarded instead. Several slip pulses before that bit arrives still discard only one bit.
- R9: `grp_data` keeps the last emitted group until the next strobe.
- R10: `grp_stb` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| rx_bits | input | 2 | Received bits; bit 1 is the newest |
| rx_cnt | input | 2 | Number of new bits this cycle (0, 1, 2; 3 treated as 2) |
| slip | input | 1 | Discard one incoming bit to move the group boundary |
| grp_data | output | GRP_W (5) | Last completed group, earliest bit in the MSB |
| grp_stb | output | 1 | One-cycle strobe marking a new group on `grp_data` |

## Verification
A wrong bit counter or pending-slip flag does not show up until the group it affects is emitted. It then appears as a strobe one or two input cycles early or late, or as a group rotated by one bit, so a fault is visible within one group time of the bit that caused it. A swapped lane order inside a two-bit cycle shows only as two adjacent bits exchanged in `grp_data`. The bench therefore feeds patterns whose neighbouring bits differ. A broken leftover path loses a bit at every boundary that splits a cycle, which shifts every following group.

// File: rtl/bitpair_packer_pkg.sv
package bitpair_packer_pkg;
  // Bits accepted by the intake stage in one cycle after slip handling.
  typedef struct packed {
    logic [1:0] kept;    // 0, 1 or 2 bits survive
    logic       older;   // valid only when kept == 2
    logic       newest;  // valid when kept != 0
  } intake_t;
endpackage

// File: rtl/bitpair_rst_sync.sv
module bitpair_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bitpair_intake.sv
module bitpair_intake
  import bitpair_packer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rx_bits,
  input  logic [1:0] rx_cnt,
  input  logic       slip,
  output intake_t    lanes
);
  logic       pend_q, pend_d;
  logic [1:0] n_new;
  logic       drop;

  always_comb begin
    // Only the upper count bit separates one bit from two.
    if (rx_cnt == 2'd0)  n_new = 2'd0;
    else if (rx_cnt[1])  n_new = 2'd2;
    else                 n_new = 2'd1;

    drop   = (slip | pend_q) & (n_new != 2'd0);
    pend_d = (slip | pend_q) & (n_new == 2'd0);

    lanes.newest = rx_bits[1];
    lanes.older  = rx_bits[0];
    lanes.kept   = n_new - {1'b0, drop};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/bitpair_accum.sv
module bitpair_accum
  import bitpair_packer_pkg::*;
#(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  intake_t          lanes,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_stb
);
  localparam int CNT_W = $clog2(GRP_W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(GRP_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(GRP_W + 1);

  logic [GRP_W-2:0] sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, total;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic             stb_q, emit, ce;
  logic [GRP_W:0]   ext;

  always_comb begin
    unique case (lanes.kept)
      2'd2:    ext = {sr_q, lanes.older, lanes.newest};
      2'd1:    ext = {1'b0, sr_q, lanes.newest};
      default: ext = {2'b00, sr_q};
    endcase

    ce    = (lanes.kept != 2'd0);
    total = cnt_q + CNT_W'(lanes.kept);
    emit  = ce & (total >= FULL);

    grp_d = grp_q;
    sr_d  = ext[GRP_W-2:0];
    cnt_d = total;
    if (emit) begin
      if (total == OVER) begin
        grp_d = ext[GRP_W:1];
        sr_d  = {{(GRP_W-2){1'b0}}, ext[0]};
      end else begin
        grp_d = ext[GRP_W-1:0];
        sr_d  = '0;
      end
      cnt_d = total - FULL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (ce) begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    grp_q <= '0;
    else if (emit) grp_q <= grp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= emit;
  end

  assign grp_data = grp_q;
  assign grp_stb  = stb_q;
endmodule

// File: rtl/bitpair_packer.sv
module bitpair_packer
  import bitpair_packer_pkg::*;
#(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rx_bits,
  input  logic [1:0]       rx_cnt,
  input  logic             slip,
  output logic [GRP_W-1:0] grp_data,
  output logic             grp_stb
);
  logic    rst_sync_n;
  intake_t lanes;

  bitpair_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitpair_intake u_intake (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rx_bits (rx_bits),
    .rx_cnt  (rx_cnt),
    .slip    (slip),
    .lanes   (lanes)
  );

  bitpair_accum #(.GRP_W(GRP_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lanes    (lanes),
    .grp_data (grp_data),
    .grp_stb  (grp_stb)
  );
endmodule

// File: rtl/bitpair_packer_chk.sv
module bitpair_packer_chk #(
  parameter int GRP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       rx_cnt,
  input logic [GRP_W-1:0] grp_data,
  input logic             grp_stb
);
  // R1: outputs quiet while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!grp_stb && grp_data == '0));

  // R2: a cycle without new bits cannot complete a group
  p_idle_no_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == 2'd0) |=> !grp_stb);

  // R9: group value held between strobes
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_stb |-> $stable(grp_data));

  // R10: no back-to-back strobes
  p_stb_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grp_stb |=> !grp_stb);
endmodule

bind bitpair_packer bitpair_packer_chk #(.GRP_W(GRP_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_cnt   (rx_cnt),
  .grp_data (grp_data),
  .grp_stb  (grp_stb)
);

// File: tb/bitpair_packer_tb.sv
`timescale 1ns/1ps
module bitpair_packer_tb;
  localparam int GRP_W = 5;

  logic             clk;
  logic             rst_n;
  logic [1:0]       rx_bits;
  logic [1:0]       rx_cnt;
  logic             slip;
  logic [GRP_W-1:0] grp_data;
  logic             grp_stb;

  int checks;
  int failures;

  // reference state built from the requirements
  bit               mq[$];
  bit               m_pend;
  logic [GRP_W-1:0] m_last;
  logic             m_stb;

  bitpair_packer #(.GRP_W(GRP_W)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_bits  (rx_bits),
    .rx_cnt   (rx_cnt),
    .slip     (slip),
    .grp_data (grp_data),
    .grp_stb  (grp_stb)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    mq.delete();
    m_pend = 1'b0;
    m_last = '0;
    m_stb  = 1'b0;
  endtask

  // One input cycle: drive, update reference, sample after the edge.
  task automatic step(input logic [1:0] b, input logic [1:0] c, input logic s, input string tag);
    int  n;
    bit  drop;
    @(negedge clk);
    rx_bits = b; rx_cnt = c; slip = s;
    n    = (c == 2'd0) ? 0 : (c[1] ? 2 : 1);
    drop = (s || m_pend) && (n != 0);
    m_pend = (s || m_pend) && (n == 0);
    if (n == 2) begin
      if (!drop) mq.push_back(b[0]);
      mq.push_back(b[1]);
    end else if (n == 1 && !drop) begin
      mq.push_back(b[1]);
    end
    m_stb = (mq.size() >= GRP_W);
    if (m_stb) begin
      for (int i = 0; i < GRP_W; i++) m_last[GRP_W-1-i] = mq.pop_front();
    end
    @(posedge clk); #1;
    check({tag, " stb"},  32'(grp_stb),  32'(m_stb));
    check({tag, " data"}, 32'(grp_data), 32'(m_last));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 2'd0, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_cnt = 2'd0; rx_bits = 2'b00; slip = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset stb",  32'(grp_stb),  32'd0);
    check("R1 reset data", 32'(grp_data), 32'd0);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    idle(3, "R1 release");
  endtask

  // R3 R5: single bits, lower lane toggled against the upper one
  task automatic t_single_bits();
    bit pat[10] = '{1,0,1,1,0, 0,1,1,1,0};
    for (int i = 0; i < 10; i++)
      step({pat[i], ~pat[i]}, 2'd1, 1'b0, "R3 single");
    check("R5 literal group", 32'(grp_data), 32'(5'b01110));
  endtask

  // R2: idle cycles with noise on the data lanes add no bits
  task automatic t_idle_noise();
    for (int i = 0; i < 6; i++) step(2'(i), 2'd0, 1'b0, "R2 idle");
    for (int i = 0; i < 5; i++) step(2'b10, 2'd1, 1'b0, "R2 after idle");
    check("R2 aligned group", 32'(grp_data), 32'(5'b11111));
  endtask

  // R4 R6 R7: two-bit cycles, boundary splitting a cycle
  task automatic t_pairs();
    logic [1:0] seq[5] = '{2'b10, 2'b01, 2'b11, 2'b00, 2'b10};
    for (int i = 0; i < 5; i++) step(seq[i], 2'd2, 1'b0, "R7 pairs");
    // bits in order: 0,1 1,0 1,1 0,0 0,1 -> groups 01101 and 10001
    check("R4 order group", 32'(grp_data), 32'(5'b10001));
  endtask

  // R4: count 3 acts like 2
  task automatic t_count3();
    for (int i = 0; i < 7; i++) step(2'(i + 1), 2'd3, 1'b0, "R4 count3");
    idle(2, "R4 count3 tail");
  endtask

  // R8: slip with bits, slip while idle, repeated slip while idle
  task automatic t_slip();
    step(2'b01, 2'd2, 1'b1, "R8 slip pair");
    step(2'b10, 2'd1, 1'b1, "R8 slip single");
    step(2'b00, 2'd0, 1'b1, "R8 slip idle");
    step(2'b00, 2'd0, 1'b1, "R8 slip idle2");
    step(2'b10, 2'd2, 1'b0, "R8 slip pending");
    for (int i = 0; i < 8; i++) step(2'(i * 3), 2'd2, 1'b0, "R8 after slip");
  endtask

  // R1: reset discards a partial group
  task automatic t_reset_mid();
    for (int i = 0; i < 3; i++) step(2'b10, 2'd1, 1'b0, "R1 partial");
    do_reset();
    step(2'b00, 2'd2, 1'b0, "R1 fresh");
    step(2'b01, 2'd2, 1'b0, "R1 fresh");
    step(2'b10, 2'd1, 1'b0, "R1 fresh");
    check("R1 fresh group", 32'(grp_data), 32'(5'b00101));
  endtask

  // R9 R10: mixed traffic with long holds
  task automatic t_mixed();
    for (int i = 0; i < 40; i++)
      step(2'((i * 7) >> 1), 2'((i * 5) % 4), (i % 13) == 6, "R9 mixed");
    idle(4, "R10 hold");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; rx_bits = 2'b00; rx_cnt = 2'd0; slip = 1'b0;
    model_clear();
    do_reset();
    t_single_bits();
    t_idle_noise();
    t_pairs();
    t_count3();
    t_slip();
    t_reset_mid();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule